// File: doc/BRIEF.md
# Horizontal Pixel Panning Shifter

This block sits in a display pipeline between pixel fetch and the palette. For every scan line it receives a stream of pixel codes, marked by a valid strobe, and moves the visible picture to the left by a programmed number of pixel positions. It does this by discarding the first N valid pixels after each line start and forwarding all later valid pixels in order. The pan code, mode flags and pad bits are captured when the line starts. That gives a stable picture even when software rewrites the settings part way through a line.

The pan code is turned into a pixel count in one of three ways. Nine-dot character mode uses an offset mapping in which code 8 means no shift. Eight-dot text and graphics modes use a direct mapping. The 256-color mode allows only even shifts. Before output, the block can replace the upper video bits with programmable pad values. Which bits are replaced depends on the mode and on a palette-size select flag.

Top module: `hpan_shifter`

## Requirements
- R1: After reset, out_valid is 0 and out_data is 0. Until the first line start, the block behaves as eight-dot mode with pan code 0, pad bits 0 and palette-size select 0. Every valid pixel is forwarded with bits 7:6 forced to 0.
- R2: In nine-dot mode (nine_dot=1, color256=0), pan codes 0 to 7 drop 1 to 8 pixels (code+1). Code 8 drops none. Codes 9 to 15 also drop none.
- R3: In eight-dot text or graphics mode (nine_dot=0, color256=0), pan codes 0 to 7 drop that many pixels. Codes 8 to 15 drop none.
- R4: In 256-color mode (color256=1), bit 0 of the pan code is taken as 0 and the eight-dot mapping is then applied. The nine_dot flag has no effect in this mode.
- R5: After a line_start, the block drops exactly the decoded number of valid input pixels and then forwards every later valid pixel in order, with a latency of one clock cycle. A pixel that is valid in the same cycle as line_start is the first pixel of the new line.
- R6: In a cycle with pix_valid low, the drop count does not advance. One cycle later, out_valid is 0 and out_data keeps its previous value.
- R7: The pan code, mode flags, palette-size select and pad bits are sampled only in a line_start cycle. A change at any other time takes effect at the next line_start.
- R8: When color256=0 and pal_sel=1, output bits 5:4 carry pad[1:0].
- R9: When color256=0, output bits 7:6 carry pad[3:2]. When color256=1, all eight output bits equal the input pixel.
- R10: When pal_sel=0, output bits 5:4 equal the input pixel bits. Output bits 3:0 always equal the input pixel bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle pulse marking the start of a scan line |
| pix_valid | input | 1 | Input pixel strobe |
| pix_data | input | 8 | Input pixel code |
| nine_dot | input | 1 | Nine-dot character mode |
| color256 | input | 1 | 256-color mode |
| pal_sel | input | 1 | Palette-size select; enables pad into bits 5:4 |
| pan_code | input | 4 | Pan code |
| pad | input | 4 | Pad bits: [1:0] for video bits 5:4, [3:2] for video bits 7:6 |
| out_valid | output | 1 | Output pixel strobe |
| out_data | output | 8 | Output pixel code |

## Verification
Every output result is due exactly one clock after the input cycle that produces it. The bench drives each input cycle just after a rising edge and checks the outputs just after the next rising edge. Its reference model updates the latched line settings and the drop count in the same cycle as the stimulus. Each expected value therefore lines up with the single output register stage. The number of pixels forwarded per line is also totalled and compared after two idle cycles, once the last output is due.

// File: rtl/hpan_pkg.sv
package hpan_pkg;

    localparam int PIX_W = 8;
    localparam int PAN_W = 4;
    localparam int PAD_W = 4;
    localparam int CNT_W = 4;

    typedef struct packed {
        logic             nine_dot;
        logic             color256;
        logic             pal_sel;
        logic [PAD_W-1:0] pad;
        logic [CNT_W-1:0] shift;
    } line_cfg_t;

    // Pan code to number of dropped pixels.
    function automatic logic [CNT_W-1:0] pan_to_shift(
        input logic [PAN_W-1:0] code,
        input logic             nine,
        input logic             c256
    );
        logic [PAN_W-1:0] eff;
        logic [CNT_W-1:0] res;
        eff = code;
        if (c256) eff[0] = 1'b0;
        if (eff[PAN_W-1]) begin
            res = '0;
        end else if (nine && !c256) begin
            res = CNT_W'(eff) + CNT_W'(1);
        end else begin
            res = CNT_W'(eff);
        end
        return res;
    endfunction

endpackage

// File: rtl/hpan_cfg_latch.sv
module hpan_cfg_latch
    import hpan_pkg::*;
#(
    parameter int P_PAN_W = PAN_W,
    parameter int P_PAD_W = PAD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               line_start,
    input  logic               nine_dot,
    input  logic               color256,
    input  logic               pal_sel,
    input  logic [P_PAN_W-1:0] pan_code,
    input  logic [P_PAD_W-1:0] pad,
    output line_cfg_t          cfg_eff
);

    line_cfg_t cfg_q;
    line_cfg_t cfg_new;

    always_comb begin
        cfg_new.nine_dot = nine_dot;
        cfg_new.color256 = color256;
        cfg_new.pal_sel  = pal_sel;
        cfg_new.pad      = pad;
        cfg_new.shift    = pan_to_shift(pan_code, nine_dot, color256);
    end

    // The line_start cycle already uses the new settings.
    assign cfg_eff = line_start ? cfg_new : cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (line_start) begin
            cfg_q <= cfg_new;
        end
    end

    p_even_shift_r4: assert property (@(posedge clk) disable iff (rst)
        cfg_q.color256 |-> (cfg_q.shift[0] == 1'b0));

    p_shift_max_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_q.shift <= CNT_W'(8));

    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !line_start |=> $stable(cfg_q));

endmodule

// File: rtl/hpan_drop_ctr.sv
module hpan_drop_ctr
    import hpan_pkg::*;
#(
    parameter int P_CNT_W = CNT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               line_start,
    input  logic               pix_valid,
    input  logic [P_CNT_W-1:0] shift,
    output logic               pass
);

    logic [P_CNT_W-1:0] rem_q;
    logic [P_CNT_W-1:0] remaining;

    assign remaining = line_start ? shift : rem_q;
    assign pass      = (remaining == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (pix_valid && !pass) begin
            rem_q <= remaining - P_CNT_W'(1);
        end else begin
            rem_q <= remaining;
        end
    end

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        rem_q <= P_CNT_W'(8));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!pix_valid && !line_start) |=> $stable(rem_q));

endmodule

// File: rtl/hpan_pad_merge.sv
module hpan_pad_merge
    import hpan_pkg::*;
#(
    parameter int P_PIX_W = PIX_W,
    parameter int P_PAD_W = PAD_W
) (
    input  logic [P_PIX_W-1:0] pix_in,
    input  logic               color256,
    input  logic               pal_sel,
    input  logic [P_PAD_W-1:0] pad,
    output logic [P_PIX_W-1:0] pix_out
);

    localparam int HALF = P_PAD_W / 2;
    localparam int LO_B = P_PIX_W - P_PAD_W;
    localparam int HI_B = P_PIX_W - HALF;

    always_comb begin
        pix_out = pix_in;
        if (!color256) begin
            pix_out[P_PIX_W-1:HI_B] = pad[P_PAD_W-1:HALF];
            if (pal_sel) begin
                pix_out[HI_B-1:LO_B] = pad[HALF-1:0];
            end
        end
    end

endmodule

// File: rtl/hpan_shifter.sv
module hpan_shifter
    import hpan_pkg::*;
#(
    parameter int P_PIX_W = PIX_W,
    parameter int P_PAN_W = PAN_W,
    parameter int P_PAD_W = PAD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               line_start,
    input  logic               pix_valid,
    input  logic [P_PIX_W-1:0] pix_data,
    input  logic               nine_dot,
    input  logic               color256,
    input  logic               pal_sel,
    input  logic [P_PAN_W-1:0] pan_code,
    input  logic [P_PAD_W-1:0] pad,
    output logic               out_valid,
    output logic [P_PIX_W-1:0] out_data
);

    line_cfg_t          cfg_eff;
    logic               pass;
    logic [P_PIX_W-1:0] merged;
    logic               eff_c256;

    hpan_cfg_latch #(.P_PAN_W(P_PAN_W), .P_PAD_W(P_PAD_W)) u_cfg (
        .clk(clk), .rst(rst), .line_start(line_start),
        .nine_dot(nine_dot), .color256(color256), .pal_sel(pal_sel),
        .pan_code(pan_code), .pad(pad), .cfg_eff(cfg_eff)
    );

    hpan_drop_ctr #(.P_CNT_W(CNT_W)) u_drop (
        .clk(clk), .rst(rst), .line_start(line_start),
        .pix_valid(pix_valid), .shift(cfg_eff.shift), .pass(pass)
    );

    hpan_pad_merge #(.P_PIX_W(P_PIX_W), .P_PAD_W(P_PAD_W)) u_merge (
        .pix_in(pix_data), .color256(cfg_eff.color256),
        .pal_sel(cfg_eff.pal_sel), .pad(cfg_eff.pad), .pix_out(merged)
    );

    assign eff_c256 = cfg_eff.color256;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= pix_valid && pass;
            if (pix_valid && pass) begin
                out_data <= merged;
            end
        end
    end

    p_out_needs_in_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(pix_valid));

    p_data_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(pix_valid) |-> $stable(out_data));

    p_c256_pass_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(eff_c256)) |-> (out_data == $past(pix_data)));

    p_low_bits_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data[3:0] == $past(pix_data[3:0])));

endmodule

// File: tb/tb_hpan_shifter.sv
module tb_hpan_shifter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_start = 1'b0;
    logic       pix_valid = 1'b0;
    logic [7:0] pix_data = '0;
    logic       nine_dot = 1'b0;
    logic       color256 = 1'b0;
    logic       pal_sel = 1'b0;
    logic [3:0] pan_code = '0;
    logic [3:0] pad = '0;
    logic       out_valid;
    logic [7:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // model state
    logic       m_nine = 0, m_c256 = 0, m_pal = 0;
    logic [3:0] m_pad = 0;
    int         m_rem = 0;
    logic       ev = 0;
    logic [7:0] ed = 0;
    int         exp_cnt = 0, obs_cnt = 0;
    string      force_tag = "";

    always #2 clk = ~clk; // 250 MHz

    hpan_shifter dut (
        .clk(clk), .rst(rst), .line_start(line_start), .pix_valid(pix_valid),
        .pix_data(pix_data), .nine_dot(nine_dot), .color256(color256),
        .pal_sel(pal_sel), .pan_code(pan_code), .pad(pad),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic int exp_shift(input int code, input logic nine, input logic c256);
        int c;
        c = c256 ? code - (code % 2) : code;
        if (c >= 8) return 0;
        if (nine && !c256) return c + 1;
        return c;
    endfunction

    function automatic logic [7:0] exp_pix(input logic [7:0] d, input logic c256,
                                           input logic pl, input logic [3:0] pd);
        logic [7:0] r;
        r = d;
        if (!c256) begin
            r[7:6] = pd[3:2];
            if (pl) r[5:4] = pd[1:0];
        end
        return r;
    endfunction

    task automatic check(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic step(input logic ls, input logic v, input logic [7:0] d);
        string tv, td;
        line_start = ls;
        pix_valid  = v;
        pix_data   = d;
        if (ls) begin
            m_nine = nine_dot; m_c256 = color256; m_pal = pal_sel; m_pad = pad;
            m_rem  = exp_shift(int'(pan_code), nine_dot, color256);
        end
        if (v) begin
            if (m_rem > 0) begin
                m_rem--; ev = 0;
            end else begin
                ev = 1; ed = exp_pix(d, m_c256, m_pal, m_pad);
            end
        end else begin
            ev = 0;
        end
        if (ev) exp_cnt++;
        @(posedge clk);
        #1;
        line_start = 0;
        pix_valid  = 0;
        if (out_valid) obs_cnt++;
        if (!v) begin tv = "R6"; td = "R6"; end
        else begin
            tv = m_c256 ? "R4" : (m_nine ? "R2" : "R3");
            td = m_c256 ? "R9" : (m_pal ? "R8" : "R10");
        end
        if (force_tag != "") begin tv = force_tag; td = force_tag; end
        check({tv, " valid"}, int'(out_valid), int'(ev));
        if (ev || !v) check({td, " data"}, int'(out_data), int'(ed));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        check("R1 reset valid", int'(out_valid), 0);
        check("R1 reset data", int'(out_data), 0);
        // no line start yet: defaults apply
        force_tag = "R1";
        for (int i = 0; i < 4; i++) step(0, 1, 8'(8'hF3 + i * 17));
        force_tag = "";
        for (int l = 0; l < 128; l++) begin
            logic nn, cc, pp;
            logic [3:0] code;
            code = 4'(l % 16);
            pp = l[4]; nn = l[5]; cc = l[6];
            nine_dot = nn; color256 = cc; pal_sel = pp;
            pan_code = code; pad = code ^ 4'hA;
            exp_cnt = 0; obs_cnt = 0;
            step(1, !l[0], 8'(l * 37 + 5));
            for (int i = 1; i < 16; i++) begin
                if (i == 2) begin
                    // mid-line rewrite must not matter until next line (R7)
                    pan_code = ~code; nine_dot = ~nn; color256 = ~cc;
                    pal_sel = ~pp; pad = ~pad;
                end
                step(0, (i % 5) != 3, 8'(l * 37 + i * 11 + 5));
            end
            step(0, 0, 8'h00);
            step(0, 0, 8'h00);
            check("R5 R7 line count", obs_cnt, exp_cnt);
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule